// File: doc/BRIEF.md
# Burst-to-State Pulse Splitter

This block takes the on/off envelope of a received wake-up call, already reduced to a single digital bit that is high while a carrier burst is present. It splits that envelope into separate pulse lines, one for each state of a fixed three-state high-low-high pattern. The first burst appears on one line and the silence that follows on a second. The second burst appears on a third line. Each line stays high for exactly as long as its state lasts, so a downstream duration checker can measure the state directly.

The envelope is asynchronous to the block clock, so it first passes through a two-flop synchroniser. A small counter of finished bursts, built from two divide-by-two stages, records which part of the pattern is in progress. Combinational gating then steers the live synchronised envelope onto the matching line. Once the second burst has ended, the counter freezes and every line stays low until the next synchronous reset.

Top module: `burst_state_splitter`

## Requirements
- R1: While `rst` is high at a clock edge, all three outputs are low after that edge, and the pattern restarts from its first burst.
- R2: The envelope reaches the outputs with a latency of exactly two clock cycles: a rise on `env_in` captured at edge k shows up on an output after edge k+1.
- R3: `state_first` equals the synchronised envelope while no burst has yet ended, so it lasts as long as the first burst.
- R4: `state_gap` is high while the synchronised envelope is low after the end of the first burst and before the start of the second.
- R5: `state_last` equals the synchronised envelope while exactly one burst has ended, so it lasts as long as the second burst.
- R6: After the second burst ends, all outputs stay low whatever `env_in` does, until the next reset.
- R7: Before the first burst starts (envelope low, no burst yet), all outputs are low.
- R8: At no clock cycle is more than one of the three outputs high.
- R9: A burst or gap only one synchronised cycle long still counts as a state and yields a one-cycle pulse on its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| env_in | input | 1 | Asynchronous envelope, high during a burst |
| state_first | output | 1 | Pulse of the first '1' state |
| state_gap | output | 1 | Pulse of the '0' state |
| state_last | output | 1 | Pulse of the final '1' state |

## Verification
The bench targets the idle period before any burst. A gap line that was a bare NOR would be high there. It also covers the cycle at which a burst ends, where a counter updated one cycle late would open a hole at the start of the gap pulse or give the gap and a burst line an overlap. One-cycle bursts and gaps check that the falling edge detection does not miss short states. Extra bursts after the pattern and a reset in the middle of the gap check that a frozen counter holds and that a restart begins cleanly at the first burst.

// File: rtl/bss_pkg.sv
package bss_pkg;

    // Number of flops in the envelope synchroniser
    localparam int SYNC_DEPTH = 2;
    // Divide-by-two stages in the burst counter
    localparam int CNT_STAGES = 2;

    typedef logic [CNT_STAGES-1:0] burst_cnt_t;

    typedef struct packed {
        logic first;
        logic gap;
        logic last;
    } state_lines_t;

    // High only while no burst has finished yet
    function automatic logic in_first_burst(input burst_cnt_t c);
        return (c == '0);
    endfunction

    // High once the last expected burst has finished
    function automatic logic pattern_over(input burst_cnt_t c);
        return c[CNT_STAGES-1];
    endfunction

endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q,
    output logic q_ahead
);
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[DEPTH-2:0], d};
    end

    assign q       = chain[DEPTH-1];
    assign q_ahead = chain[DEPTH-2];
endmodule

// File: rtl/bss_burst_counter.sv
module bss_burst_counter
    import bss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       env_now,
    input  logic       env_next,
    output burst_cnt_t cnt
);
    // A burst ends at the edge where the synchronised envelope drops.
    // The next synchroniser stage shows this one cycle ahead, so the count
    // and the envelope change on the same edge.
    logic ending;
    logic [CNT_STAGES:0] carry;

    assign ending   = env_now & ~env_next & ~pattern_over(cnt);
    assign carry[0] = ending;

    for (genvar i = 0; i < CNT_STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)           cnt[i] <= 1'b0;
            else if (carry[i]) cnt[i] <= ~cnt[i];
        end
        assign carry[i+1] = carry[i] & cnt[i];
    end
endmodule

// File: rtl/bss_steer.sv
module bss_steer
    import bss_pkg::*;
(
    input  logic         env,
    input  burst_cnt_t   cnt,
    output state_lines_t lines
);
    logic started;

    always_comb begin
        started     = |cnt;
        lines.first = env & in_first_burst(cnt);
        lines.last  = env & ~lines.first & ~pattern_over(cnt);
        lines.gap   = ~(pattern_over(cnt) | lines.first | lines.last) & started;
    end
endmodule

// File: rtl/burst_state_splitter.sv
module burst_state_splitter
    import bss_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic env_in,
    output logic state_first,
    output logic state_gap,
    output logic state_last
);
    logic         env_s;
    logic         env_ahead;
    burst_cnt_t   cnt;
    state_lines_t lines;

    bss_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       (env_in),
        .q       (env_s),
        .q_ahead (env_ahead)
    );

    bss_burst_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .env_now  (env_s),
        .env_next (env_ahead),
        .cnt      (cnt)
    );

    bss_steer u_steer (
        .env   (env_s),
        .cnt   (cnt),
        .lines (lines)
    );

    assign state_first = lines.first;
    assign state_gap   = lines.gap;
    assign state_last  = lines.last;
endmodule

// File: rtl/bss_checker.sv
module bss_checker (
    input logic clk,
    input logic rst,
    input logic env_in,
    input logic state_first,
    input logic state_gap,
    input logic state_last
);
    logic seen_first, seen_gap, seen_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_first <= 1'b0;
            seen_gap   <= 1'b0;
            seen_last  <= 1'b0;
        end else begin
            if (state_first) seen_first <= 1'b1;
            if (state_gap)   seen_gap   <= 1'b1;
            if (state_last)  seen_last  <= 1'b1;
        end
    end

    // R8
    one_line_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({state_first, state_gap, state_last}));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !(state_first || state_gap || state_last));

    // R4
    gap_after_first_chk: assert property (@(posedge clk) disable iff (rst)
        state_gap |-> seen_first);

    // R5
    last_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        state_last |-> seen_gap);

    // R6
    frozen_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_last && !state_last) |-> !(state_first || state_gap || state_last));

    // R3
    first_once_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_gap || seen_last) |-> !state_first);

    logic unused_env;
    assign unused_env = env_in;
endmodule

bind burst_state_splitter bss_checker u_bss_checker (
    .clk         (clk),
    .rst         (rst),
    .env_in      (env_in),
    .state_first (state_first),
    .state_gap   (state_gap),
    .state_last  (state_last)
);

// File: tb/burst_state_splitter_test.sv
module burst_state_splitter_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic env_in = 1'b0;
    logic state_first, state_gap, state_last;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit short_mode = 1'b0;
    bit finished = 1'b0;

    // Behavioural reference: envelope delay line and number of finished bursts
    int m_h1 = 0, m_env = 0, m_prev = 0, m_done = 0, m_rst_tail = 0;

    always #4 clk = ~clk;

    burst_state_splitter uut (
        .clk         (clk),
        .rst         (rst),
        .env_in      (env_in),
        .state_first (state_first),
        .state_gap   (state_gap),
        .state_last  (state_last)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_h1 = 0; m_env = 0; m_prev = 0; m_done = 0; m_rst_tail = 1;
        end else begin
            m_rst_tail = 0;
            m_prev = m_env;
            m_env  = m_h1;
            m_h1   = env_in;
            if (m_prev == 1 && m_env == 0 && m_done < 2) m_done++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished && cycles > 0) begin
            int ef, eg, el;
            string t;
            ef = (m_env == 1 && m_done == 0);
            eg = (m_env == 0 && m_done == 1);
            el = (m_env == 1 && m_done == 1);
            t  = "";
            if (m_rst_tail == 1)                 t = "R1";
            else if (short_mode)                 t = "R9";
            else if (m_done == 2)                t = "R6";
            else if (m_done == 0 && m_env == 0)  t = "R7";
            check(state_first == ef, (t == "") ? "R3" : t, state_first, ef);
            check(state_gap   == eg, (t == "") ? "R4" : t, state_gap, eg);
            check(state_last  == el, (t == "") ? "R5" : t, state_last, el);
            check($countones({state_first, state_gap, state_last}) <= 1, "R8",
                  $countones({state_first, state_gap, state_last}), 1);
        end
    end

    task automatic drive(input bit v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            env_in = v;
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        env_in = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        do_reset(3);
        // R1: outputs low just after reset
        check(!(state_first | state_gap | state_last), "R1",
              {state_first, state_gap, state_last}, 0);
        // R7: idle
        drive(1'b0, 6);
        // R2: latency of a rising envelope
        @(negedge clk); env_in = 1'b1;
        @(negedge clk);
        check(state_first == 1'b0, "R2", state_first, 0);
        @(negedge clk);
        check(state_first == 1'b1, "R2", state_first, 1);
        // Normal pattern: burst, gap, burst, then extra bursts ignored
        drive(1'b1, 3);
        drive(1'b0, 7);
        drive(1'b1, 4);
        drive(1'b0, 5);
        drive(1'b1, 6);   // R6: ignored
        drive(1'b0, 3);
        drive(1'b1, 2);
        drive(1'b0, 4);
        check(!(state_first | state_gap | state_last), "R6",
              {state_first, state_gap, state_last}, 0);
        // Reset in the middle of the gap, then restart
        do_reset(1);
        drive(1'b1, 3);
        drive(1'b0, 2);
        @(negedge clk);
        check(state_gap == 1'b1, "R4", state_gap, 1);
        do_reset(2);
        drive(1'b0, 3);
        // R9: one-cycle burst, gap and burst
        short_mode = 1'b1;
        drive(1'b1, 1);
        drive(1'b0, 1);
        drive(1'b1, 1);
        drive(1'b0, 6);
        short_mode = 1'b0;
        drive(1'b1, 3);
        drive(1'b0, 3);
        // Long pattern after a fresh reset
        do_reset(1);
        drive(1'b0, 2);
        drive(1'b1, 40);
        drive(1'b0, 55);
        drive(1'b1, 33);
        drive(1'b0, 10);
        drive(1'b1, 1);
        drive(1'b0, 5);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule